// File: doc/BRIEF.md
# Serial Programming Register File for a Frequency Synthesizer

This block receives programming words over a three-line serial bus (data, bit clock and an active-low enable) and holds the settings that a phase-locked-loop synthesizer needs: the main divider ratio, the reference divider ratio, the charge-pump current code, a software power bit and the lock-detector enable. All three bus lines are brought into the block's own clock domain through synchronizer stages. The shifting and loading logic is sampled, so the bus clock must be much slower than the system clock. The same system clock drives the divider counters.

A burst starts when enable goes low. Each rising bus clock edge then shifts one bit into a 21-bit register. When enable returns high, the last four bits shifted in are taken as an address and the seventeen bits before them as data. One load strobe steers the data into the addressed latch. Control fields take effect at once. A new divider ratio is parked until the divider that uses it signals a terminal count, so a count that is already running always finishes with the ratio it started with. Programming works in the same way whether the software power bit is set or clear.

Top module: `synth_prog_regs`

## Requirements
- R1: After reset every output is zero: both ratios, cp_code, sw_pwr, lock_en and test_word.
- R2: A frame is 21 bits, sent most significant bit first. The first 17 bits are the data field d[16:0], starting with d16. The last 4 bits are the address a[3:0], ending with a0.
- R3: Only the last 21 bits shifted in before enable rises form the frame. Any leading bits are dropped, and the number of clocks in a burst is never checked.
- R4: Bus clock edges that arrive while enable is high shift nothing. A burst with no clock edges reloads the frame left over from the previous burst.
- R5: Each rising edge of enable gives exactly one load. A frame whose address is none of 0000, 0100, 0101 or 0110 changes no output.
- R6: Address 0110 loads d[16:0] as the main divider ratio. The new ratio reaches main_ratio only at the first clock with main_tc high after the load. Without main_tc, main_ratio holds.
- R7: Address 0101 loads d[10:0] as the reference divider ratio. The new ratio reaches ref_ratio only at the first clock with ref_tc high after the load.
- R8: Address 0101 also sets lock_en from d16, sw_pwr from d15 and cp_code from d[14:13]. These take effect within a few clocks of the load and do not wait for ref_tc.
- R9: Address 0100 sets sw_pwr from d15 and leaves every other output unchanged.
- R10: Address 0000 stores d[16:0] in test_word.
- R11: If a divider ratio is loaded twice before the divider's terminal count, the second value is the one applied. A terminal count with no load pending leaves the ratio unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and divider clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clk | input | 1 | Serial bit clock; bits shift on its rising edge |
| bus_data | input | 1 | Serial data |
| bus_en_n | input | 1 | Active-low burst enable; a rising edge loads the frame |
| main_tc | input | 1 | Main divider terminal-count strobe |
| ref_tc | input | 1 | Reference divider terminal-count strobe |
| main_ratio | output | 17 | Applied main divider ratio |
| ref_ratio | output | 11 | Applied reference divider ratio |
| cp_code | output | 2 | Charge-pump current code |
| sw_pwr | output | 1 | Software power bit |
| lock_en | output | 1 | Lock-detector enable |
| test_word | output | 17 | Contents of the test register |

## Verification
The assertions assume that each bus line stays steady for at least three system clocks between changes. They also assume that a bus clock edge never reaches the synchronizers in the same cycle as an enable edge, so the sampled shift and load never race. The bench holds every bus level for three clocks and leaves three idle clocks on either side of each enable edge. It raises a terminal-count strobe for one clock only, and only after the load has settled. Under these conditions the only moments at which a ratio may change are the strobes the bench chooses.

// File: rtl/synth_prog_pkg.sv
// Shared constants for the synthesizer programming register file.
// Assumes a 17-bit data field followed by a 4-bit address in every frame.
package synth_prog_pkg;
    localparam int DATA_W   = 17;
    localparam int ADDR_W   = 4;
    localparam int REF_W    = 11;
    localparam int CP_W     = 2;
    localparam int FRAME_W  = DATA_W + ADDR_W;

    localparam logic [ADDR_W-1:0] ADDR_TEST = 4'b0000;
    localparam logic [ADDR_W-1:0] ADDR_PWR  = 4'b0100;
    localparam logic [ADDR_W-1:0] ADDR_REF  = 4'b0101;
    localparam logic [ADDR_W-1:0] ADDR_MAIN = 4'b0110;

    localparam int POS_LOCK  = 16;
    localparam int POS_PWR   = 15;
    localparam int POS_CP_LO = 13;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_TEST,
        TGT_PWR,
        TGT_REF,
        TGT_MAIN
    } target_e;

    function automatic target_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            ADDR_TEST: return TGT_TEST;
            ADDR_PWR:  return TGT_PWR;
            ADDR_REF:  return TGT_REF;
            ADDR_MAIN: return TGT_MAIN;
            default:   return TGT_NONE;
        endcase
    endfunction
endpackage

// File: rtl/prog_sync.sv
// Multi-stage synchronizer for a group of independent slow inputs.
// Assumes each input stays steady for several clocks; each bit has its own
// reset value, so an idle-high line does not show a false edge after reset.
module prog_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Move the sampled value one stage further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else if (s == 0) chain[s] <= din;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/prog_shifter.sv
// Serial front end: shifts one bit per rising bus clock while enable is low,
// and raises a one-cycle frame strobe when enable rises.
// Assumes synchronized inputs, and no bus clock edge in the same cycle as an
// enable edge.
module prog_shifter
    import synth_prog_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_clk,
    input  logic               s_dat,
    input  logic               s_en_n,
    output logic [FRAME_W-1:0] frame,
    output logic               frame_stb
);
    logic               clk_q;
    logic               en_q;
    logic [FRAME_W-1:0] sr;
    logic               clk_rise;

    // Keep last cycle's levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= 1'b0;
            en_q  <= 1'b1;
        end else begin
            clk_q <= s_clk;
            en_q  <= s_en_n;
        end
    end

    assign clk_rise = s_clk & ~clk_q;

    // Shift in a new bit on each enabled bus clock rise; older bits fall off.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else if (clk_rise && !s_en_n) sr <= {sr[FRAME_W-2:0], s_dat};
    end

    assign frame     = sr;
    assign frame_stb = s_en_n & ~en_q;

    // R4: while enable is high, the shift register keeps its contents.
    a_r4_idle_bus_holds: assert property (@(posedge clk) disable iff (!rst_n)
        s_en_n |=> $stable(sr));

    // R5: one rising enable edge gives one load strobe, never two in a row.
    a_r5_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> !frame_stb);
endmodule

// File: rtl/prog_ratio_slot.sv
// Holds one divider ratio. A loaded value waits as pending and is applied at
// the divider's terminal-count strobe, so a running count is never disturbed.
// Assumes tc is high for one clock at each divider wrap.
module prog_ratio_slot #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         tc,
    output logic [W-1:0] ratio
);
    logic [W-1:0] pend;
    logic         pv;

    // Apply the pending ratio at the count boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) ratio <= '0;
        else if (tc && pv) ratio <= pend;
    end

    // Park new loads; the latest load wins, and a commit clears the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            pv   <= 1'b0;
        end else begin
            if (tc && pv) pv <= 1'b0;
            if (wr) begin
                pend <= wdata;
                pv   <= 1'b1;
            end
        end
    end

    // R6 / R7: the applied ratio only moves at a terminal count.
    a_r6_ratio_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !tc |=> $stable(ratio));

    // R11: a commit with no new load leaves nothing pending.
    a_r11_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && pv && !wr) |=> !pv);

    // R11: a load always leaves a value pending.
    a_r11_load_pends: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> pv);
endmodule

// File: rtl/prog_latches.sv
// Decodes the frame address on the load strobe and steers the data field to
// the test, power, reference/control or main latch. Unused addresses are
// dropped. Assumes frame is steady while frame_stb is high.
module prog_latches
    import synth_prog_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] frame,
    input  logic               frame_stb,
    input  logic               main_tc,
    input  logic               ref_tc,
    output logic [DATA_W-1:0]  main_ratio,
    output logic [REF_W-1:0]   ref_ratio,
    output logic [CP_W-1:0]    cp_code,
    output logic               sw_pwr,
    output logic               lock_en,
    output logic [DATA_W-1:0]  test_word
);
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    target_e           tgt;
    logic              wr_main;
    logic              wr_ref;

    assign addr    = frame[ADDR_W-1:0];
    assign data    = frame[FRAME_W-1:ADDR_W];
    assign tgt     = frame_stb ? decode_addr(addr) : TGT_NONE;
    assign wr_main = (tgt == TGT_MAIN);
    assign wr_ref  = (tgt == TGT_REF);

    prog_ratio_slot #(.W(DATA_W)) u_main (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_main),
        .wdata (data),
        .tc    (main_tc),
        .ratio (main_ratio)
    );

    prog_ratio_slot #(.W(REF_W)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_ref),
        .wdata (data[REF_W-1:0]),
        .tc    (ref_tc),
        .ratio (ref_ratio)
    );

    // Control fields follow the load at once, without waiting for a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cp_code <= '0;
            sw_pwr  <= 1'b0;
            lock_en <= 1'b0;
        end else if (tgt == TGT_REF) begin
            cp_code <= data[POS_CP_LO +: CP_W];
            sw_pwr  <= data[POS_PWR];
            lock_en <= data[POS_LOCK];
        end else if (tgt == TGT_PWR) begin
            sw_pwr  <= data[POS_PWR];
        end
    end

    // Test register keeps the whole data field.
    always_ff @(posedge clk) begin
        if (!rst_n) test_word <= '0;
        else if (tgt == TGT_TEST) test_word <= data;
    end

    // R8: control and test state change only after a load strobe.
    a_r8_ctrl_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable({cp_code, sw_pwr, lock_en, test_word}));

    // R5: a frame with an unused address changes no latch.
    a_r5_unused_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && decode_addr(addr) == TGT_NONE)
        |=> $stable({cp_code, sw_pwr, lock_en, test_word}));

    // R9: the power-only address never touches the charge-pump or lock fields.
    a_r9_pwr_only: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && decode_addr(addr) == TGT_PWR)
        |=> $stable({cp_code, lock_en}));
endmodule

// File: rtl/synth_prog_regs.sv
// Top of the synthesizer programming register file: synchronizes the three
// bus lines, assembles frames and drives the divider and control latches.
// Assumes the bus runs several times slower than clk.
module synth_prog_regs
    import synth_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clk,
    input  logic              bus_data,
    input  logic              bus_en_n,
    input  logic              main_tc,
    input  logic              ref_tc,
    output logic [DATA_W-1:0] main_ratio,
    output logic [REF_W-1:0]  ref_ratio,
    output logic [CP_W-1:0]   cp_code,
    output logic              sw_pwr,
    output logic              lock_en,
    output logic [DATA_W-1:0] test_word
);
    localparam int BUS_LINES = 3;

    logic [BUS_LINES-1:0] bus_sync;
    logic [FRAME_W-1:0]   frame;
    logic                 frame_stb;

    prog_sync #(
        .W       (BUS_LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({bus_en_n, bus_data, bus_clk}),
        .dout  (bus_sync)
    );

    prog_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_clk     (bus_sync[0]),
        .s_dat     (bus_sync[1]),
        .s_en_n    (bus_sync[2]),
        .frame     (frame),
        .frame_stb (frame_stb)
    );

    prog_latches u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame      (frame),
        .frame_stb  (frame_stb),
        .main_tc    (main_tc),
        .ref_tc     (ref_tc),
        .main_ratio (main_ratio),
        .ref_ratio  (ref_ratio),
        .cp_code    (cp_code),
        .sw_pwr     (sw_pwr),
        .lock_en    (lock_en),
        .test_word  (test_word)
    );
endmodule

// File: tb/synth_prog_regs_test.sv
// Bench for the programming register file: sweeps ratio and control values,
// then covers leading bits, idle bus clocks, unused addresses and reloads.
module synth_prog_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_clk = 1'b0;
    logic        bus_data = 1'b0;
    logic        bus_en_n = 1'b1;
    logic        main_tc = 1'b0;
    logic        ref_tc = 1'b0;
    logic [16:0] main_ratio;
    logic [10:0] ref_ratio;
    logic [1:0]  cp_code;
    logic        sw_pwr;
    logic        lock_en;
    logic [16:0] test_word;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    synth_prog_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data),
        .bus_en_n(bus_en_n), .main_tc(main_tc), .ref_tc(ref_tc),
        .main_ratio(main_ratio), .ref_ratio(ref_ratio), .cp_code(cp_code),
        .sw_pwr(sw_pwr), .lock_en(lock_en), .test_word(test_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_bit(input logic b);
        bus_data = b;
        repeat (3) @(negedge clk);
        bus_clk = 1'b1;
        repeat (3) @(negedge clk);
        bus_clk = 1'b0;
    endtask

    task automatic send(input logic [16:0] d, input logic [3:0] a, input int lead);
        logic [20:0] f;
        f = {d, a};
        @(negedge clk);
        bus_en_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < lead; i++) bus_bit(i[0]);
        for (int i = 20; i >= 0; i--) bus_bit(f[i]);
        repeat (3) @(negedge clk);
        bus_en_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_main;
        main_tc = 1'b1;
        @(negedge clk);
        main_tc = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_ref;
        ref_tc = 1'b1;
        @(negedge clk);
        ref_tc = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [16:0] exp_main;
        logic [10:0] exp_ref;
        logic [1:0]  exp_cp;
        logic        exp_pwr, exp_lock;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        check("R1 main", main_ratio, 0);
        check("R1 ref", ref_ratio, 0);
        check("R1 ctrl", {cp_code, sw_pwr, lock_en}, 0);
        check("R1 test", test_word, 0);

        // R2 / R6: main ratio sweep, held until the terminal count
        exp_main = '0;
        for (int k = 0; k < 24; k++) begin
            logic [16:0] v;
            v = 17'((k * 5471 + 300) & 32'h1ffff);
            send(v, 4'b0110, 0);
            check("R6 main holds before tc", main_ratio, exp_main);
            pulse_main();
            exp_main = v;
            check("R2 main applied", main_ratio, exp_main);
        end

        // R7 / R8: reference ratio and control fields
        exp_ref = '0;
        for (int k = 0; k < 16; k++) begin
            logic [10:0] pr;
            pr = 11'((k * 131 + 8) & 32'h7ff);
            exp_cp = 2'(k % 4);
            exp_pwr = k[2];
            exp_lock = k[3];
            send({exp_lock, exp_pwr, exp_cp, 2'b11, pr}, 4'b0101, 0);
            check("R8 control fields", {lock_en, sw_pwr, cp_code}, {exp_lock, exp_pwr, exp_cp});
            check("R7 ref holds before tc", ref_ratio, exp_ref);
            pulse_ref();
            exp_ref = pr;
            check("R7 ref applied", ref_ratio, exp_ref);
            check("R7 main untouched", main_ratio, exp_main);
        end
        exp_pwr = sw_pwr;

        // R9: power-only address
        send(17'h1ffff, 4'b0100, 0);
        check("R9 pwr set", sw_pwr, 1);
        check("R9 others", {lock_en, cp_code}, {exp_lock, exp_cp});
        send(17'h00000, 4'b0100, 0);
        check("R9 pwr clear", sw_pwr, 0);
        pulse_ref();
        check("R9 ref untouched", ref_ratio, exp_ref);

        // R5: unused addresses are dropped
        send(17'h1ffff, 4'b1111, 0);
        send(17'h1ffff, 4'b0001, 0);
        pulse_main();
        pulse_ref();
        check("R5 unused main", main_ratio, exp_main);
        check("R5 unused ref", ref_ratio, exp_ref);
        check("R5 unused ctrl", {lock_en, sw_pwr, cp_code}, {exp_lock, 1'b0, exp_cp});
        check("R5 unused test", test_word, 0);

        // R4: clocks while enable is high shift nothing; empty burst reloads
        send(17'h0a5a3, 4'b0110, 0);
        pulse_main();
        for (int i = 0; i < 4; i++) bus_bit(1'b0);
        @(negedge clk);
        bus_en_n = 1'b0;
        repeat (6) @(negedge clk);
        bus_en_n = 1'b1;
        repeat (8) @(negedge clk);
        check("R4 no shift while idle", test_word, 0);
        pulse_main();
        check("R4 reloaded frame", main_ratio, 17'h0a5a3);

        // R3: leading bits are dropped
        send(17'h13579, 4'b0110, 6);
        pulse_main();
        check("R3 leading bits dropped", main_ratio, 17'h13579);
        send(17'h00246, 4'b0110, 11);
        pulse_main();
        check("R3 long burst", main_ratio, 17'h00246);

        // R10: test register
        send(17'h15555, 4'b0000, 0);
        check("R10 test written", test_word, 17'h15555);
        send(17'h00000, 4'b0000, 0);
        check("R10 test cleared", test_word, 0);

        // R11: latest pending load wins; idle tc changes nothing
        send(17'h01111, 4'b0110, 0);
        send(17'h02222, 4'b0110, 0);
        check("R11 still old", main_ratio, 17'h00246);
        pulse_main();
        check("R11 latest wins", main_ratio, 17'h02222);
        pulse_main();
        check("R11 idle tc", main_ratio, 17'h02222);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule